// File: doc/BRIEF.md
# Programmable UART Receiver

This block turns an asynchronous serial line into parallel characters. It is timed by a one-cycle enable, `rx_tick`, that pulses at sixteen times the bit rate on the system clock. A falling line level seen on a tick starts a frame. The receiver checks that level again half a bit later and then samples every following bit at its centre. Each frame has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and stop bits.

The word length, parity enable and parity sense are taken from the configuration inputs when the start bit is detected. At the centre of the first stop bit, the character and its error status move into the holding outputs, and `data_avail` is raised. The host then takes the character and clears `data_avail` with either a reset strobe or a read strobe. The receiver re-arms as soon as the first stop bit has been sampled, so it accepts any number of stop bits without being told how many to expect.

Top module: `uart_rx_core`

## Requirements
- R1: After a synchronous reset, `rx_data` is zero and `data_avail`, `err_par`, `err_ovr`, `err_frm` and `err_par_or_ovr` are all low.
- R2: `cfg_len` selects the number of data bits as 5 plus its value (00=5, 01=6, 10=7, 11=8). Data bits arrive least significant first and appear in the low bits of `rx_data`. The unused upper bits read as zero.
- R3: When `cfg_par_en` is high, one parity bit follows the data. With `cfg_par_odd` low the data plus parity must hold an even count of ones, and with it high an odd count. A mismatch sets `err_par` for that character. When parity is disabled there is no parity bit and `err_par` stays low.
- R4: `err_frm` is set for a character whose first stop bit is sampled low, and cleared for one whose first stop bit is sampled high.
- R5: Each bit cell is 16 ticks long, and nothing advances on a cycle without a tick. `data_avail` and the holding outputs update in the middle of the first stop bit cell: between 13 and 23 system clocks after that cell starts, when ticks arrive every second clock.
- R6: A low pulse that has ended before the start-bit midpoint is rejected. No character is loaded, and the holding outputs stay unchanged.
- R7: If `data_avail` is still high when a new character is loaded, `err_ovr` is set. Otherwise it is cleared on that load.
- R8: `err_par_or_ovr` is high whenever `err_par` or `err_ovr` is high.
- R9: A one-cycle pulse on `da_clr` clears `data_avail` on the next clock.
- R10: A one-cycle pulse on `rd_strobe` clears `data_avail` on the next clock. Neither strobe changes `rx_data` or the error flags, which hold until the next character is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_tick | input | 1 | Enable at sixteen times the bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Word length code, 5 plus value |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| da_clr | input | 1 | Strobe that clears data_avail |
| rd_strobe | input | 1 | Holding-register read strobe, clears data_avail |
| rx_data | output | 8 | Received character, zero-filled above word length |
| data_avail | output | 1 | A character is waiting |
| err_par | output | 1 | Parity mismatch on the held character |
| err_ovr | output | 1 | Held character overwrote an unread one |
| err_frm | output | 1 | First stop bit was low |
| err_par_or_ovr | output | 1 | Parity or overrun error |

## Verification
The line passes through a two-stage synchronizer and the start is picked up on the next tick, so the holding outputs change 13 to 23 clocks into the first stop cell. The bench records the clock on which `data_avail` rises and checks that it falls in that window, measured from the start edge it drove. It reads the character and flags only after the whole frame and an idle gap have gone by. The clear strobes take effect at the next edge, so the bench checks `data_avail` on the falling edge right after releasing a strobe. For glitch rejection it waits several frame times before confirming that nothing moved.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;

    localparam int unsigned CHAR_W   = 8;
    localparam int unsigned MIN_BITS = 5;
    localparam int unsigned IDX_W    = $clog2(CHAR_W);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
    } rx_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
    } rx_char_t;

    // index of the last data bit for a length code
    function automatic logic [IDX_W-1:0] last_bit_idx(input logic [1:0] len);
        return IDX_W'(MIN_BITS - 1) + IDX_W'(len);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
`timescale 1ns/1ps
module rx_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
`timescale 1ns/1ps
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  rx_cfg_t  cfg,
    output logic     load_o,
    output rx_char_t char_o
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [CHAR_W-1:0]  shreg;
    logic               par_acc;
    logic               perr;
    rx_cfg_t            cfg_q;
    logic               hit;

    always_comb begin
        if (state == RX_START) hit = (cnt == MID_CNT);
        else                   hit = (cnt == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            perr    <= 1'b0;
            cfg_q   <= '0;
            load_o  <= 1'b0;
            char_o  <= '0;
        end else begin
            load_o <= 1'b0;
            if (tick) begin
                if (state != RX_IDLE) cnt <= hit ? '0 : cnt + 1'b1;
                unique case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (!line) begin
                            state <= RX_START;
                            cfg_q <= cfg;
                        end
                    end
                    RX_START: if (hit) begin
                        if (line) begin
                            state <= RX_IDLE;
                        end else begin
                            state   <= RX_DATA;
                            idx     <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                            perr    <= 1'b0;
                        end
                    end
                    RX_DATA: if (hit) begin
                        shreg[idx] <= line;
                        par_acc    <= par_acc ^ line;
                        if (idx == last_bit_idx(cfg_q.len))
                            state <= cfg_q.par_en ? RX_PAR : RX_STOP;
                        else
                            idx <= idx + 1'b1;
                    end
                    RX_PAR: if (hit) begin
                        perr  <= par_acc ^ line ^ cfg_q.par_odd;
                        state <= RX_STOP;
                    end
                    RX_STOP: if (hit) begin
                        load_o         <= 1'b1;
                        char_o.data    <= shreg;
                        char_o.par_err <= cfg_q.par_en & perr;
                        char_o.frm_err <= ~line;
                        state          <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    p_tick_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(state) && $stable(cnt)));

    p_glitch_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == MID_CNT && line) |=> state == RX_IDLE);

    p_load_from_stop_r5: assert property (@(posedge clk) disable iff (rst)
        load_o |-> $past(state) == RX_STOP);

    p_load_single_r5: assert property (@(posedge clk) disable iff (rst)
        load_o |=> !load_o);

endmodule

// File: rtl/rx_holding.sv
`timescale 1ns/1ps
module rx_holding
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  rx_char_t          char_in,
    input  logic              clr_strobe,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] data_q,
    output logic              avail_q,
    output logic              par_q,
    output logic              ovr_q,
    output logic              frm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            avail_q <= 1'b0;
            par_q   <= 1'b0;
            ovr_q   <= 1'b0;
            frm_q   <= 1'b0;
        end else if (load) begin
            data_q  <= char_in.data;
            par_q   <= char_in.par_err;
            frm_q   <= char_in.frm_err;
            ovr_q   <= avail_q;
            avail_q <= 1'b1;
        end else if (clr_strobe || rd_strobe) begin
            avail_q <= 1'b0;
        end
    end

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        ((clr_strobe || rd_strobe) && !load) |=> !avail_q);

    p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
        (load && avail_q) |=> ovr_q);

    p_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(data_q) && $stable(par_q) && $stable(frm_q) && $stable(ovr_q)));

    p_load_sets_avail_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> avail_q);

endmodule

// File: rtl/uart_rx_core.sv
`timescale 1ns/1ps
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_tick,
    input  logic              rx_serial,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              da_clr,
    input  logic              rd_strobe,
    output logic [CHAR_W-1:0] rx_data,
    output logic              data_avail,
    output logic              err_par,
    output logic              err_ovr,
    output logic              err_frm,
    output logic              err_par_or_ovr
);
    logic     line_s;
    logic     load;
    rx_char_t char_w;
    rx_cfg_t  cfg_w;

    assign cfg_w = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd};

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rx_serial),
        .d_out (line_s)
    );

    rx_deframer #(.OVS(OVS)) u_deframe (
        .clk    (clk),
        .rst    (rst),
        .tick   (rx_tick),
        .line   (line_s),
        .cfg    (cfg_w),
        .load_o (load),
        .char_o (char_w)
    );

    rx_holding u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .char_in    (char_w),
        .clr_strobe (da_clr),
        .rd_strobe  (rd_strobe),
        .data_q     (rx_data),
        .avail_q    (data_avail),
        .par_q      (err_par),
        .ovr_q      (err_ovr),
        .frm_q      (err_frm)
    );

    assign err_par_or_ovr = err_par | err_ovr;

    p_combined_r8: assert property (@(posedge clk) disable iff (rst)
        (err_par || err_ovr) |-> err_par_or_ovr);

endmodule

// File: tb/sim_uart_rx_core.sv
`timescale 1ns/1ps
module sim_uart_rx_core;

    localparam int CELL = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_tick;
    logic       rx_serial;
    logic [1:0] cfg_len;
    logic       cfg_par_en;
    logic       cfg_par_odd;
    logic       da_clr;
    logic       rd_strobe;
    logic [7:0] rx_data;
    logic       data_avail;
    logic       err_par;
    logic       err_ovr;
    logic       err_frm;
    logic       err_par_or_ovr;

    int applied = 0;
    int miscompares = 0;
    int cyc = 0;
    int rise_cyc = -1;
    logic da_prev = 1'b0;
    int t0;
    int stop_start;

    always #2.5 clk = ~clk;

    uart_rx_core u0 (
        .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_serial(rx_serial),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .da_clr(da_clr), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .data_avail(data_avail), .err_par(err_par), .err_ovr(err_ovr),
        .err_frm(err_frm), .err_par_or_ovr(err_par_or_ovr)
    );

    initial begin
        rx_tick = 1'b0;
        forever begin
            @(negedge clk);
            rx_tick = ~rx_tick;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (data_avail && !da_prev) rise_cyc = cyc;
        da_prev = data_avail;
    end

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic [7:0] data;
        logic       badp;
        logic       bads;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{len: 2'd3, pen: 1'b0, podd: 1'b0, data: 8'hA5, badp: 1'b0, bads: 1'b0},
        '{len: 2'd0, pen: 1'b0, podd: 1'b0, data: 8'hFF, badp: 1'b0, bads: 1'b0},
        '{len: 2'd1, pen: 1'b1, podd: 1'b0, data: 8'h3C, badp: 1'b0, bads: 1'b0},
        '{len: 2'd2, pen: 1'b1, podd: 1'b1, data: 8'h55, badp: 1'b0, bads: 1'b0},
        '{len: 2'd3, pen: 1'b1, podd: 1'b0, data: 8'h81, badp: 1'b1, bads: 1'b0},
        '{len: 2'd3, pen: 1'b1, podd: 1'b1, data: 8'h7E, badp: 1'b1, bads: 1'b0},
        '{len: 2'd0, pen: 1'b1, podd: 1'b1, data: 8'h0B, badp: 1'b0, bads: 1'b1},
        '{len: 2'd2, pen: 1'b0, podd: 1'b0, data: 8'hC3, badp: 1'b0, bads: 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied = applied + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input logic [1:0] len);
        return 8'((9'd1 << (5 + len)) - 9'd1);
    endfunction

    task automatic send(input vec_t v);
        int nb;
        logic [7:0] d;
        logic pbit;
        nb = 5 + int'(v.len);
        d = v.data & mask_of(v.len);
        pbit = (^d) ^ v.podd ^ v.badp;
        cfg_len = v.len;
        cfg_par_en = v.pen;
        cfg_par_odd = v.podd;
        rise_cyc = -1;
        rx_serial = 1'b0;
        t0 = cyc;
        repeat (CELL) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_serial = d[i];
            repeat (CELL) @(negedge clk);
        end
        if (v.pen) begin
            rx_serial = pbit;
            repeat (CELL) @(negedge clk);
        end
        stop_start = t0 + CELL * (1 + nb + (v.pen ? 1 : 0));
        rx_serial = ~v.bads;
        repeat (CELL) @(negedge clk);
        rx_serial = 1'b1;
        repeat (48) @(negedge clk);
    endtask

    task automatic pulse_clear(input logic use_rd);
        if (use_rd) rd_strobe = 1'b1; else da_clr = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        da_clr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares = miscompares + 1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rx_serial = 1'b1;
        cfg_len = 2'd3;
        cfg_par_en = 1'b0;
        cfg_par_odd = 1'b0;
        da_clr = 1'b0;
        rd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 data_avail", data_avail, 0);
        chk("R1 flags", {err_par, err_ovr, err_frm, err_par_or_ovr}, 0);

        // table walk
        for (int k = 0; k < 8; k++) begin
            vec_t v;
            int off;
            v = VECS[k];
            send(v);
            chk("R5 data_avail raised", data_avail, 1);
            off = rise_cyc - stop_start;
            chk("R5 load inside stop-cell window", (rise_cyc >= 0 && off >= 13 && off <= 23), 1);
            chk("R2 data", rx_data, v.data & mask_of(v.len));
            chk("R3 parity error", err_par, v.pen & v.badp);
            chk("R4 framing error", err_frm, v.bads);
            chk("R7 no overrun", err_ovr, 0);
            chk("R8 combined", err_par_or_ovr, v.pen & v.badp);
            if (k % 2 == 0) begin
                pulse_clear(1'b1);
                chk("R10 read clears data_avail", data_avail, 0);
            end else begin
                pulse_clear(1'b0);
                chk("R9 strobe clears data_avail", data_avail, 0);
            end
            chk("R10 data held after clear", rx_data, v.data & mask_of(v.len));
            chk("R10 flags held after clear", {err_par, err_frm}, {v.pen & v.badp, v.bads});
        end

        // R7 overrun: two characters with no clear between
        send('{len: 2'd3, pen: 1'b0, podd: 1'b0, data: 8'h11, badp: 1'b0, bads: 1'b0});
        chk("R7 first char no overrun", err_ovr, 0);
        send('{len: 2'd3, pen: 1'b0, podd: 1'b0, data: 8'h22, badp: 1'b0, bads: 1'b0});
        chk("R7 overrun set", err_ovr, 1);
        chk("R8 combined from overrun", err_par_or_ovr, 1);
        chk("R7 newest data kept", rx_data, 8'h22);
        pulse_clear(1'b0);
        chk("R9 clear after overrun", data_avail, 0);
        chk("R10 overrun held after clear", err_ovr, 1);
        send('{len: 2'd3, pen: 1'b0, podd: 1'b0, data: 8'h33, badp: 1'b0, bads: 1'b0});
        chk("R7 overrun cleared by next load", err_ovr, 0);
        chk("R8 combined low", err_par_or_ovr, 0);
        pulse_clear(1'b1);

        // R6 glitch rejection: low for 4 ticks only
        rx_serial = 1'b0;
        repeat (8) @(negedge clk);
        rx_serial = 1'b1;
        repeat (600) @(negedge clk);
        chk("R6 glitch loads nothing", data_avail, 0);
        chk("R6 data unchanged", rx_data, 8'h33);
        chk("R6 flags unchanged", {err_par, err_ovr, err_frm}, 0);

        // R6 after a glitch a real frame is still received
        send('{len: 2'd1, pen: 1'b0, podd: 1'b0, data: 8'h2A, badp: 1'b0, bads: 1'b0});
        chk("R6 frame after glitch", rx_data, 8'h2A);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule